// File: doc/BRIEF.md
# Loss-of-clock detector

This block decides whether a monitored line clock is still running. It does all of its judging in the processor clock domain. The only logic clocked by the monitored clock is a prescaler: the monitored clock runs a programmable divider, and the divider flips a single toggle bit once per division period. That toggle crosses into the processor domain through a two-flop synchronizer. An edge detector then turns each flip into one transition pulse.

Two counters in the processor domain act on those pulses. An idle counter measures processor cycles since the last transition. When it reaches the programmed entry threshold, the loss status is raised. While the status is raised, a transition counter tallies detected transitions. The status drops once the programmed exit threshold is met. If the idle window elapses again before the exit count is met, the tally starts over from zero. The two thresholds are independent, which gives the status hysteresis.

There is no data stream at this block's boundary. Every pin is a plain control or status signal, so no valid/ready handshake and no back-pressure rules apply.

Top module: `clk_loss_monitor`

## Requirements
- R1: After a processor-domain reset, `loss_o` is 1. It stays 1 until the exit criterion of R6 is met.
- R2: The monitored clock is divided by `div_val`+1. The divided toggle flips once every `div_val`+1 rising edges of `mon_clk`, and each flip counts as one transition.
- R3: Each divided-clock flip is detected in the processor domain through a two-flop synchronizer and an edge detector. It reaches the counters no later than 3 processor cycles after the `mon_clk` rising edge that caused it.
- R4: `loss_o` rises after `entry_thr` consecutive processor cycles with no detected transition. A value of 0 is treated as 1.
- R5: Every detected transition restarts the idle count. A monitored clock whose transitions are closer together than `entry_thr` cycles never raises `loss_o`.
- R6: While `loss_o` is 1, it falls on the detected transition that brings the transition count to `exit_thr`. A value of 0 is treated as 1.
- R7: While `loss_o` is 1, if the entry idle window elapses again before the exit count is reached, the transition count restarts from zero.
- R8: `loss_o` rises only in a cycle with no detected transition, and falls only in a cycle with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitored line clock |
| mon_rst_n | input | 1 | Active-low asynchronous reset for the prescaler |
| proc_clk | input | 1 | Processor clock; all detection runs here |
| proc_rst_n | input | 1 | Active-low asynchronous reset for the processor domain |
| div_val | input | 16 | Prescaler setting; the divide ratio is this value plus one |
| entry_thr | input | 16 | Idle processor cycles that declare loss |
| exit_thr | input | 16 | Detected transitions that clear loss |
| loss_o | output | 1 | 1 while the monitored clock is judged absent |

## Verification
The bench targets three things. The first is the hysteresis gap, where a few transitions fall short of the exit count; a design that cleared on the first transition would drop `loss_o` too early. The second is the restart case, where the idle window expires between two bursts of transitions. A design that kept its tally across the timeout would clear after the second burst instead of needing a further transition. The third is the prescaler: with a divided period longer than the entry window, a correct design keeps `loss_o` high while the clock is running. A divider that ignored `div_val`, or divided by `div_val` instead of `div_val`+1, would instead see the clock as present or shift the timing.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned CLKMON_CNT_W       = 16;
  localparam int unsigned CLKMON_SYNC_STAGES = 2;

  typedef enum logic {
    CLK_PRESENT = 1'b0,
    CLK_LOST    = 1'b1
  } clk_state_e;
endpackage

// File: rtl/clkmon_divider.sv
module clkmon_divider #(
  parameter int unsigned DIV_W = clkmon_pkg::CLKMON_CNT_W
) (
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tog_o
);
  logic [DIV_W-1:0] cnt_q;

  // Flip once per (div_val + 1) monitored rising edges.
  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      cnt_q <= '0;
      tog_o <= 1'b0;
    end else if (cnt_q >= div_val) begin
      cnt_q <= '0;
      tog_o <= ~tog_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkmon_sync_edge.sv
module clkmon_sync_edge #(
  parameter int unsigned STAGES = clkmon_pkg::CLKMON_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  // One pulse per toggle, whichever direction it flipped.
  assign pulse_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/clkmon_loss_fsm.sv
module clkmon_loss_fsm #(
  parameter int unsigned THR_W = clkmon_pkg::CLKMON_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic [THR_W-1:0] entry_thr,
  input  logic [THR_W-1:0] exit_thr,
  output logic             loss_o
);
  import clkmon_pkg::*;

  localparam logic [THR_W:0] ONE_W = {{THR_W{1'b0}}, 1'b1};

  clk_state_e       state_q;
  logic [THR_W-1:0] idle_q;
  logic [THR_W-1:0] trans_q;
  logic [THR_W:0]   entry_eff, exit_eff, idle_inc, trans_inc;
  logic             timeout, exit_hit;

  // A zero threshold behaves as one.
  assign entry_eff = (entry_thr == '0) ? ONE_W : {1'b0, entry_thr};
  assign exit_eff  = (exit_thr  == '0) ? ONE_W : {1'b0, exit_thr};
  assign idle_inc  = {1'b0, idle_q}  + ONE_W;
  assign trans_inc = {1'b0, trans_q} + ONE_W;

  assign timeout  = !pulse_i && (idle_inc >= entry_eff);
  assign exit_hit = pulse_i && (trans_inc >= exit_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (pulse_i || timeout) begin
      idle_q <= '0;
    end else begin
      idle_q <= idle_inc[THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CLK_LOST;
      trans_q <= '0;
    end else if (timeout) begin
      state_q <= CLK_LOST;
      trans_q <= '0;
    end else if (state_q == CLK_LOST && pulse_i) begin
      if (exit_hit) begin
        state_q <= CLK_PRESENT;
        trans_q <= '0;
      end else begin
        trans_q <= trans_inc[THR_W-1:0];
      end
    end else if (state_q == CLK_PRESENT) begin
      trans_q <= '0;
    end
  end

  assign loss_o = (state_q == CLK_LOST);
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int unsigned DIV_W  = clkmon_pkg::CLKMON_CNT_W,
  parameter int unsigned THR_W  = clkmon_pkg::CLKMON_CNT_W,
  parameter int unsigned STAGES = clkmon_pkg::CLKMON_SYNC_STAGES
) (
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic             proc_clk,
  input  logic             proc_rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [THR_W-1:0] entry_thr,
  input  logic [THR_W-1:0] exit_thr,
  output logic             loss_o
);
  logic div_tog;
  logic edge_pulse;

  clkmon_divider #(.DIV_W(DIV_W)) u_div (
    .mon_clk   (mon_clk),
    .mon_rst_n (mon_rst_n),
    .div_val   (div_val),
    .tog_o     (div_tog)
  );

  clkmon_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk     (proc_clk),
    .rst_n   (proc_rst_n),
    .async_i (div_tog),
    .pulse_o (edge_pulse)
  );

  clkmon_loss_fsm #(.THR_W(THR_W)) u_fsm (
    .clk       (proc_clk),
    .rst_n     (proc_rst_n),
    .pulse_i   (edge_pulse),
    .entry_thr (entry_thr),
    .exit_thr  (exit_thr),
    .loss_o    (loss_o)
  );
endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk #(
  parameter int unsigned THR_W = 16
) (
  input logic             proc_clk,
  input logic             proc_rst_n,
  input logic             pulse,
  input logic             loss_o,
  input logic [THR_W-1:0] entry_thr
);
  logic             was_rst;
  logic [THR_W:0]   idle_c;
  logic [THR_W-1:0] entry_q;
  logic [THR_W:0]   entry_eff;

  assign entry_eff = (entry_thr == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, entry_thr};

  always_ff @(posedge proc_clk or negedge proc_rst_n) begin
    if (!proc_rst_n) was_rst <= 1'b1;
    else             was_rst <= 1'b0;
  end

  // Independent count of cycles since the last transition; restarts when the threshold moves.
  always_ff @(posedge proc_clk or negedge proc_rst_n) begin
    if (!proc_rst_n) begin
      idle_c  <= '0;
      entry_q <= '0;
    end else begin
      entry_q <= entry_thr;
      if (pulse || entry_thr != entry_q) idle_c <= '0;
      else if (!(&idle_c))               idle_c <= idle_c + 1'b1;
    end
  end

  p_reset_asserted_r1: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    was_rst |-> loss_o);

  p_idle_window_r4: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    (idle_c > entry_eff) |-> loss_o);

  p_rise_only_idle_r8: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    $rose(loss_o) |-> !$past(pulse));

  p_fall_on_edge_r6: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    $fell(loss_o) |-> $past(pulse));

  p_pulse_single_r3: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    pulse |=> !pulse);
endmodule

bind clk_loss_monitor clk_loss_monitor_chk #(.THR_W(THR_W)) chk_i (
  .proc_clk   (proc_clk),
  .proc_rst_n (proc_rst_n),
  .pulse      (edge_pulse),
  .loss_o     (loss_o),
  .entry_thr  (entry_thr)
);

// File: tb/clk_loss_monitor_tb_top.sv
module clk_loss_monitor_tb_top;
  logic        proc_clk   = 1'b0;
  logic        mon_clk    = 1'b0;
  logic        proc_rst_n = 1'b0;
  logic        mon_rst_n  = 1'b0;
  logic [15:0] div_val    = 16'd0;
  logic [15:0] entry_thr  = 16'd20;
  logic [15:0] exit_thr   = 16'd4;
  logic        loss;

  clk_loss_monitor dut_i (
    .mon_clk    (mon_clk),
    .mon_rst_n  (mon_rst_n),
    .proc_clk   (proc_clk),
    .proc_rst_n (proc_rst_n),
    .div_val    (div_val),
    .entry_thr  (entry_thr),
    .exit_thr   (exit_thr),
    .loss_o     (loss)
  );

  always #4 proc_clk = ~proc_clk;

  int cyc = 0;
  always @(posedge proc_clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  exp;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // Monitor: pops expectations whose cycle has come and compares at the falling edge.
  always @(negedge proc_clk) begin
    exp_t it;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      it = sb_q.pop_front();
      n_checks++;
      if (loss !== it.exp) begin
        n_fail++;
        $display("FAIL %s: loss_o=%0b expected %0b (cycle %0d)", it.tag, loss, it.exp, cyc);
      end
    end
  end

  task automatic expect_at(int k, logic v, string tag);
    sb_q.push_back('{cyc + k, v, tag});
    repeat (k) @(negedge proc_clk);
    #1;
  endtask

  // One monitored clock period spanning two processor cycles.
  task automatic mon_edge();
    @(negedge proc_clk) mon_clk = 1'b1;
    @(negedge proc_clk) mon_clk = 1'b0;
  endtask

  task automatic mon_run(int n);
    for (int i = 0; i < n; i++) mon_edge();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge proc_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge proc_clk);
    proc_rst_n = 1'b1;
    mon_rst_n  = 1'b1;

    // R1: status starts asserted.
    expect_at(2, 1'b1, "R1 reset state");

    // R6: three transitions are short of exit_thr=4.
    mon_run(3);
    expect_at(4, 1'b1, "R6 below exit count");
    // R6/R3: fourth transition clears within the sync latency.
    mon_run(1);
    expect_at(4, 1'b0, "R6 R3 exit on fourth transition");

    // R5: steady clock, transitions every 2 cycles, entry 20.
    mon_run(15);
    expect_at(1, 1'b0, "R5 running clock stays present");
    mon_run(15);
    expect_at(1, 1'b0, "R5 idle count restarts");

    // R4/R3: clock stops; loss rises about entry_thr after the last transition.
    expect_at(20, 1'b0, "R4 before entry window");
    expect_at(4, 1'b1, "R4 after entry window");

    // R7: entry 10, exit 3. Two transitions, timeout, two more: still lost.
    entry_thr = 16'd10;
    exit_thr  = 16'd3;
    mon_run(2);
    expect_at(20, 1'b1, "R7 lost after timeout");
    mon_run(2);
    expect_at(3, 1'b1, "R7 count restarted after timeout");
    mon_run(1);
    expect_at(5, 1'b0, "R7 R6 third transition after restart");

    // R2: divide by 5 gives a transition every 10 cycles, longer than entry 8.
    div_val   = 16'd4;
    entry_thr = 16'd8;
    exit_thr  = 16'd2;
    mon_run(60);
    expect_at(1, 1'b1, "R2 R7 divided period beyond entry window");
    entry_thr = 16'd14;
    mon_run(20);
    expect_at(1, 1'b0, "R2 divided period inside entry window");

    // R1: a fresh processor reset re-asserts the status.
    @(negedge proc_clk) proc_rst_n = 1'b0;
    repeat (3) @(negedge proc_clk);
    proc_rst_n = 1'b1;
    expect_at(1, 1'b1, "R1 re-reset state");

    repeat (2) @(negedge proc_clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule